// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block chooses which control-store word a horizontally microcoded stack machine runs next. Each cycle it combines three inputs: the next-address field of the current microinstruction, a three-bit jump-control field, and status flags saved from the ALU one clock earlier. The result is registered as the microprogram counter. In the same clock edge, the word held at that new address is read from a synchronous control store into the microinstruction register.

Machine instructions are decoded by multiway dispatch. When the dispatch bit is set, the opcode byte is ORed into the low address bits, so the first step of each instruction routine sits at the control-store address equal to its opcode. Later steps of a routine can sit anywhere in the store. The sequencer always follows the explicit next-address field and never adds one to the current address. Conditional branches OR a saved flag into the top address bit, so that the two possible targets of a branch are 256 words apart.

The control store has a simple write port, which is used to load microcode before running.

Top module: `microseq`

## Requirements
- R1: While rst_n is low, mpc and mir read 0 and both saved flags are cleared. On the first edge after release, the sequencer computes its address with flags that are 0.
- R2: With jctl = 3'b000, the next mpc equals next_addr exactly. This holds for every 9-bit value, including an address that is not the current mpc + 1 and an address equal to the current mpc (a self-loop).
- R3: jctl bit 0 (zero jam) ORs the saved zero flag into mpc bit 8.
- R4: jctl bit 1 (negative jam) ORs the saved negative flag into mpc bit 8.
- R5: jctl bit 2 (dispatch) makes mpc[7:0] equal to next_addr[7:0] OR opcode. When bit 2 is clear, mpc[7:0] equals next_addr[7:0].
- R6: alu_z and alu_n are captured into the saved flags at every rising edge. The address computed at an edge uses the flags captured at the edge before it, not the current alu_z and alu_n inputs.
- R7: After each edge out of reset, mir holds the control-store word at the new mpc. A word written through cs_we/cs_waddr/cs_wdata at an edge is not visible to a read of the same address at that same edge, which returns the previous contents. The word is visible from the next edge onward.
- R8: Dispatch and both jams can be active in the same cycle. All of them then apply together: bit 8 gets the OR of next_addr[8] and the enabled flags, and bits 7:0 get the OR with the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| next_addr | input | 9 | Next-address field of the current microinstruction |
| jctl | input | 3 | Jump control: bit 2 dispatch, bit 1 negative jam, bit 0 zero jam |
| alu_z | input | 1 | ALU zero result of this cycle |
| alu_n | input | 1 | ALU negative result of this cycle |
| opcode | input | 8 | Opcode byte from the instruction stream |
| cs_we | input | 1 | Control-store write enable |
| cs_waddr | input | 9 | Control-store write address |
| cs_wdata | input | 36 | Control-store write data |
| mpc | output | 9 | Microprogram counter |
| mir | output | 36 | Microinstruction read at mpc |

## Verification
Opcode dispatch and a flag jam can land in the same cycle. The flag jam can itself be fed by a flag saved from the cycle before. The bench provokes this by sweeping all eight jump-control codes against every combination of the saved flags, using opcodes and base addresses that have bits both set and clear. It also drives the current ALU flag inputs to values different from the saved ones. It judges each result with an arithmetic model of bit 8 and bits 7:0, and checks that the word read from the store matches the new address.

// File: rtl/microseq.sv
module microseq #(
  parameter int AW  = 9,
  parameter int DW  = 36,
  parameter int OPW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] next_addr,
  input  logic [2:0]    jctl,
  input  logic          alu_z,
  input  logic          alu_n,
  input  logic [OPW-1:0] opcode,
  input  logic          cs_we,
  input  logic [AW-1:0] cs_waddr,
  input  logic [DW-1:0] cs_wdata,
  output logic [AW-1:0] mpc,
  output logic [DW-1:0] mir
);
  localparam int HI    = AW - 1;
  localparam int DEPTH = 1 << AW;

  logic          z_q, n_q;
  logic          hi_bit;
  logic [HI-1:0] op_ext, lo_bits;
  logic [AW-1:0] nxt;
  logic [DW-1:0] store [DEPTH];

  assign op_ext  = (HI)'(opcode);
  assign hi_bit  = next_addr[HI] | (jctl[1] & n_q) | (jctl[0] & z_q);
  assign lo_bits = next_addr[HI-1:0] | (jctl[2] ? op_ext : '0);
  assign nxt     = {hi_bit, lo_bits};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      z_q <= 1'b0;
      n_q <= 1'b0;
      mpc <= '0;
      mir <= '0;
    end else begin
      z_q <= alu_z;
      n_q <= alu_n;
      mpc <= nxt;
      mir <= store[nxt];
    end
  end

  always_ff @(posedge clk) begin
    if (cs_we) store[cs_waddr] <= cs_wdata;
  end

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> (mpc == '0 && mir == '0));
  p_plain_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    jctl == 3'b000 |=> mpc == $past(next_addr));
  p_low_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !jctl[2] |=> mpc[HI-1:0] == $past(next_addr[HI-1:0]));
  p_dispatch_or_r5: assert property (@(posedge clk) disable iff (!rst_n)
    jctl[2] |=> (mpc[HI-1:0] & $past(op_ext)) == $past(op_ext));
  p_zero_jam_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && jctl[0] && $past(alu_z)) |=> mpc[HI]);
  p_neg_jam_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && jctl[1] && $past(alu_n)) |=> mpc[HI]);
  p_top_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    next_addr[HI] |=> mpc[HI]);
endmodule

// File: tb/sim_microseq.sv
module sim_microseq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  next_addr = '0;
  logic [2:0]  jctl = '0;
  logic        alu_z = 1'b0, alu_n = 1'b0;
  logic [7:0]  opcode = '0;
  logic        cs_we = 1'b0;
  logic [8:0]  cs_waddr = '0;
  logic [35:0] cs_wdata = '0;
  logic [8:0]  mpc;
  logic [35:0] mir;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [35:0] model [512];
  bit mz = 0, mn = 0;

  always #10 clk = ~clk;

  microseq u0 (.clk, .rst_n, .next_addr, .jctl, .alu_z, .alu_n, .opcode,
               .cs_we, .cs_waddr, .cs_wdata, .mpc, .mir);

  function automatic logic [35:0] word_of(input logic [8:0] a);
    return {a, ~a, a ^ 9'h155, 9'(a * 5)};
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic [8:0] na, input logic [2:0] jc,
                      input logic [7:0] op, input bit z, input bit n);
    logic [8:0] e;
    next_addr = na; jctl = jc; opcode = op; alu_z = z; alu_n = n;
    e[8]   = na[8] | (jc[1] & mn) | (jc[0] & mz);
    e[7:0] = na[7:0] | (jc[2] ? op : 8'h00);
    @(posedge clk);
    mz = z; mn = n;
    @(negedge clk);
    chk(req, {27'd0, mpc}, {27'd0, e});
    chk({req, " R7"}, mir, model[e]);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    alu_z = 1'b1; alu_n = 1'b1;
    @(negedge clk);
    cs_we = 1'b1;
    for (int a = 0; a < 512; a++) begin
      cs_waddr = 9'(a); cs_wdata = word_of(9'(a)); model[a] = word_of(9'(a));
      @(negedge clk);
    end
    cs_we = 1'b0;
    chk("R1 mpc", {27'd0, mpc}, 36'd0);
    chk("R1 mir", mir, 36'd0);
    rst_n = 1'b1;
    // R1: flags cleared, so jams have no effect on the first edge
    step("R1 flags", 9'h020, 3'b011, 8'h00, 1'b0, 1'b0);

    // R2: plain sequencing over every address, non-sequential order
    for (int a = 0; a < 512; a++)
      step("R2", 9'((a * 37 + 5) % 512), 3'b000, 8'hFF, 1'b0, 1'b0);
    step("R2 to 0x60", 9'h060, 3'b000, 8'h00, 1'b0, 1'b0);
    step("R2 jump 0x6E", 9'h06E, 3'b000, 8'h00, 1'b0, 1'b0);
    step("R2 go 0x28", 9'h028, 3'b000, 8'h00, 1'b0, 1'b0);
    step("R2 selfloop", 9'h028, 3'b000, 8'h00, 1'b0, 1'b0);
    step("R2 selfloop again", 9'h028, 3'b000, 8'h00, 1'b0, 1'b0);

    // R5: dispatch on every opcode from both base addresses
    for (int o = 0; o < 256; o++) begin
      step("R5 base0", 9'h000, 3'b100, 8'(o), 1'b0, 1'b0);
      step("R5 base100", 9'h100, 3'b100, 8'(o), 1'b0, 1'b0);
    end

    // R6: current alu inputs do not steer the branch, saved ones do
    step("R6 prime", 9'h010, 3'b000, 8'h00, 1'b1, 1'b0);
    step("R6 uses saved z", 9'h010, 3'b001, 8'h00, 1'b0, 1'b1);
    step("R6 ignores live z", 9'h010, 3'b001, 8'h00, 1'b1, 1'b0);

    // R3 R4 R8: all jump codes against all saved flag pairs
    for (int jc = 0; jc < 8; jc++)
      for (int f = 0; f < 4; f++)
        for (int b = 0; b < 4; b++) begin
          step("R8 prime", 9'h003, 3'b000, 8'h00, f[0], f[1]);
          step(jc[2] ? "R8" : (jc[1] ? "R4" : "R3"),
               9'((b * 9'h0A5) ^ (b[1] ? 9'h100 : 9'h000)), 3'(jc),
               8'(8'h5A ^ (b * 8'h33)), ~f[0], ~f[1]);
        end

    // R7: read at an edge that writes the same address returns old data
    cs_we = 1'b1; cs_waddr = 9'h0C3; cs_wdata = 36'hABCDE1234;
    step("R7 old", 9'h0C3, 3'b000, 8'h00, 1'b0, 1'b0);
    model[9'h0C3] = 36'hABCDE1234;
    cs_we = 1'b0;
    step("R7 new", 9'h0C3, 3'b000, 8'h00, 1'b0, 1'b0);

    // R1: reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 re-reset mpc", {27'd0, mpc}, 36'd0);
    chk("R1 re-reset mir", mir, 36'd0);
    mz = 0; mn = 0;
    rst_n = 1'b1;
    step("R1 flags after", 9'h044, 3'b011, 8'h00, 1'b0, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule